// File: doc/BRIEF.md
# Flash Write Completion Poller

This block sits in a host-side flash controller. After the controller has issued a program or erase command to a parallel flash, a single start pulse hands control to this poller. The poller then reads the status location over and over until the flash reports that the write has finished. It takes a mode, an expected data word, and a read port with a request/acknowledge handshake. When it is done it gives a one-cycle completion pulse, with either a pass/fail result or a timeout flag.

Two completion criteria are supported. The first watches a status bit that toggles on every read while the flash is busy. The second watches a status bit that reads inverted (program) or low (erase) until the write lands. Completion is asynchronous to the host, so one read can catch the part mid-transition. For that reason, an apparent completion only counts once two more reads in a row also meet the criterion. A miss restarts the search.

After confirmation the poller waits a settling interval, because the rest of the data bus becomes valid later than the status bit. It then makes one final full-word read and compares that word with the expected value. A security-ID program mode forces the toggle criterion whatever the data bit shows. A cycle budget stops a write that never completes.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, rd_req_o, done_o, pass_o and timeout_o are all 0.
- R2: A start_i pulse while idle sets rd_req_o in the next cycle, and the poller latches mode_i and exp_data_i at that time. A request is held high until a cycle with rd_ack_i high, which completes that read with rd_data_i valid. A start_i arriving while a poll is in progress has no effect.
- R3: Mode 2'b00 (toggle): a returned word is a hit when its bit 6 equals bit 6 of the previous read of the same poll. The first read of a poll is never a hit.
- R4: Mode 2'b01 (program data polling): a read is a hit when bit 7 equals bit 7 of the expected word. Mode 2'b10 (erase data polling): a read is a hit when bit 7 is 1.
- R5: Completion is confirmed only by CONFIRM_READS+1 consecutive hits (default 3). A miss resets the run, and polling continues.
- R6: Mode 2'b11 (security-ID program) uses the toggle criterion of R3 only. Bit 7 has no effect on it.
- R7: After confirmation, rd_req_o stays low for exactly SETTLE_CYC cycles. Then one final read is requested.
- R8: One cycle after the final read returns, done_o pulses with timeout_o=0, and pass_o=1 exactly when the final word equals the expected word. pass_o and timeout_o change only in a cycle where done_o is high.
- R9: When a poll read that does not complete confirmation returns while TIMEOUT_CYC or more cycles have passed in the poll, the poll ends: no settle and no final read, and done_o pulses one cycle later with timeout_o=1 and pass_o=0.
- R10: done_o is high for exactly one cycle per poll, and rd_req_o is low while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a poll (sampled while idle) |
| mode_i | input | 2 | 00 toggle, 01 program data poll, 10 erase data poll, 11 security-ID toggle |
| exp_data_i | input | DATA_W | Word that was written (all ones for erase) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_ack_i | input | 1 | Read returned this cycle |
| rd_data_i | input | DATA_W | Returned word, valid with rd_ack_i |
| done_o | output | 1 | One-cycle end-of-poll pulse |
| pass_o | output | 1 | Final word matched the expected word |
| timeout_o | output | 1 | Poll ended on the cycle budget |

## Verification
The bound checker watches port-level rules on every cycle:
- the request is held until acknowledged;
- done is a single-cycle pulse with no request alongside it;
- the result flags move only with done;
- timeout and pass are never set together.

Some behaviour only the bench scenarios can show: the count of reads each criterion needs, a rejected false completion followed by a real one, the security-ID mode ignoring a matching data bit, the settle gap length, and a mismatching final word. The bench shows these through read counts and a per-cycle comparison against a behavioural model.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
    typedef enum logic [1:0] {
        MODE_TOGGLE     = 2'b00,
        MODE_DATA_PROG  = 2'b01,
        MODE_DATA_ERASE = 2'b10,
        MODE_SECID      = 2'b11
    } poll_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_POLL,
        ST_SETTLE,
        ST_FINAL
    } poll_state_e;
endpackage

// File: rtl/fdp_status_eval.sv
module fdp_status_eval
    import fdp_pkg::*;
(
    input  poll_mode_e mode_i,
    input  logic       tog_bit_i,
    input  logic       dp_bit_i,
    input  logic       exp_dp_bit_i,
    input  logic       prev_tog_i,
    input  logic       prev_ok_i,
    output logic       hit_o
);
    always_comb begin
        unique case (mode_i)
            MODE_DATA_PROG:  hit_o = (dp_bit_i == exp_dp_bit_i);
            MODE_DATA_ERASE: hit_o = dp_bit_i;
            default:         hit_o = prev_ok_i && (tog_bit_i == prev_tog_i);
        endcase
    end
endmodule

// File: rtl/fdp_counter.sv
module fdp_counter #(
    parameter int unsigned MAX_VAL = 15,
    localparam int unsigned CW     = $clog2(MAX_VAL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_VAL);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (inc_i && cnt_q != LIMIT)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import fdp_pkg::*;
#(
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned TOG_BIT       = 6,
    parameter int unsigned DP_BIT        = 7,
    parameter int unsigned CONFIRM_READS = 2,
    parameter int unsigned SETTLE_CYC    = 50,
    parameter int unsigned TIMEOUT_CYC   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] exp_data_i,
    output logic              rd_req_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              done_o,
    output logic              pass_o,
    output logic              timeout_o
);
    localparam int unsigned HIT_W = $clog2(CONFIRM_READS + 2);
    localparam int unsigned TMO_W = $clog2(TIMEOUT_CYC + 1);
    localparam int unsigned SET_W = $clog2(SETTLE_CYC + 1);
    localparam logic [HIT_W-1:0] CONF_LIM = HIT_W'(CONFIRM_READS);
    localparam logic [TMO_W-1:0] TMO_LIM  = TMO_W'(TIMEOUT_CYC);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

    typedef struct packed {
        poll_state_e       st;
        poll_mode_e        mode;
        logic [DATA_W-1:0] exp;
        logic              prev_tog;
        logic              prev_ok;
        logic [HIT_W-1:0]  hits;
        logic              req;
        logic              done;
        logic              pass;
        logic              tmo;
    } poll_regs_t;

    poll_regs_t r_d, r_q;

    logic             hit;
    logic [TMO_W-1:0] timer_cnt;
    logic [SET_W-1:0] settle_cnt;

    fdp_status_eval u_eval (
        .mode_i       (r_q.mode),
        .tog_bit_i    (rd_data_i[TOG_BIT]),
        .dp_bit_i     (rd_data_i[DP_BIT]),
        .exp_dp_bit_i (r_q.exp[DP_BIT]),
        .prev_tog_i   (r_q.prev_tog),
        .prev_ok_i    (r_q.prev_ok),
        .hit_o        (hit)
    );

    // cycles spent polling, cleared while idle
    fdp_counter #(.MAX_VAL(TIMEOUT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (r_q.st == ST_IDLE),
        .inc_i (r_q.st == ST_POLL),
        .cnt_o (timer_cnt)
    );

    // settle interval, cleared while polling
    fdp_counter #(.MAX_VAL(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (r_q.st == ST_POLL),
        .inc_i (r_q.st == ST_SETTLE),
        .cnt_o (settle_cnt)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st      = ST_POLL;
                    r_d.mode    = poll_mode_e'(mode_i);
                    r_d.exp     = exp_data_i;
                    r_d.prev_ok = 1'b0;
                    r_d.hits    = '0;
                    r_d.req     = 1'b1;
                end
            end
            ST_POLL: begin
                if (rd_ack_i) begin
                    r_d.prev_tog = rd_data_i[TOG_BIT];
                    r_d.prev_ok  = 1'b1;
                    r_d.hits     = hit ? r_q.hits + 1'b1 : '0;
                    if (hit && r_q.hits == CONF_LIM) begin
                        r_d.st  = ST_SETTLE;
                        r_d.req = 1'b0;
                    end else if (timer_cnt >= TMO_LIM) begin
                        r_d.st   = ST_IDLE;
                        r_d.req  = 1'b0;
                        r_d.done = 1'b1;
                        r_d.pass = 1'b0;
                        r_d.tmo  = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (settle_cnt == SET_LAST) begin
                    r_d.st  = ST_FINAL;
                    r_d.req = 1'b1;
                end
            end
            ST_FINAL: begin
                if (rd_ack_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.req  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.pass = (rd_data_i == r_q.exp);
                    r_d.tmo  = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_req_o  = r_q.req;
    assign done_o    = r_q.done;
    assign pass_o    = r_q.pass;
    assign timeout_o = r_q.tmo;
endmodule

module fdp_checker (
    input logic clk,
    input logic rst_n,
    input logic rd_req_o,
    input logic rd_ack_i,
    input logic done_o,
    input logic pass_o,
    input logic timeout_o
);
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_no_req_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !rd_req_o);
    a_r8_pass_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass_o) |-> done_o);
    a_r8_tmo_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(timeout_o) |-> done_o);
    a_r9_tmo_not_pass: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !pass_o);
endmodule

bind flash_done_poller fdp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req_o  (rd_req_o),
    .rd_ack_i  (rd_ack_i),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .timeout_o (timeout_o)
);

// File: tb/flash_done_poller_tb.sv
module flash_done_poller_tb;
    localparam int TMO  = 40;
    localparam int SET  = 5;
    localparam int CONF = 2;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, ack = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] expw = 16'h0, rdata = 16'h0;
    logic        req, done, pass, tmo;

    always #10 clk = ~clk;

    flash_done_poller #(.DATA_W(16), .TOG_BIT(6), .DP_BIT(7), .CONFIRM_READS(CONF),
                        .SETTLE_CYC(SET), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .exp_data_i(expw),
        .rd_req_o(req), .rd_ack_i(ack), .rd_data_i(rdata),
        .done_o(done), .pass_o(pass), .timeout_o(tmo));

    int checks = 0, errors = 0;
    logic [15:0] resp_q[$];
    int reads = 0, wait_c = 0, low_run = 0, last_low = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // flash-side responder: variable latency, scripted words then expected word
    always @(negedge clk) begin
        if (ack) ack = 1'b0;
        else if (req) begin
            if (wait_c >= reads % 3) begin
                ack    = 1'b1;
                rdata  = (resp_q.size() > 0) ? resp_q.pop_front() : expw;
                reads++;
                wait_c = 0;
            end else wait_c++;
        end
        if (!req) low_run++;
        else begin
            if (low_run > 0) last_low = low_run;
            low_run = 0;
        end
    end

    // behavioural reference model
    int m_ph = 0, m_k = 0, m_j = 0, m_streak = 0;
    bit m_prev = 0, m_prev_ok = 0, m_hit = 0;
    logic [1:0]  m_mode = 0;
    logic [15:0] m_exp = 0;
    bit e_req = 0, e_done = 0, e_pass = 0, e_tmo = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; e_req = 0; e_done = 0; e_pass = 0; e_tmo = 0;
        end else begin
            e_done = 0;
            case (m_ph)
                0: if (start) begin
                    m_ph = 1; e_req = 1; m_k = 0; m_streak = 0; m_prev_ok = 0;
                    m_mode = mode; m_exp = expw;
                end
                1: begin
                    if (ack) begin
                        if (m_mode == 2'b01)      m_hit = (rdata[7] == m_exp[7]);
                        else if (m_mode == 2'b10) m_hit = rdata[7];
                        else                      m_hit = m_prev_ok && (rdata[6] == m_prev);
                        m_prev = rdata[6]; m_prev_ok = 1;
                        m_streak = m_hit ? m_streak + 1 : 0;
                        if (m_streak == CONF + 1) begin
                            m_ph = 2; e_req = 0; m_j = 0;
                        end else if (m_k >= TMO) begin
                            m_ph = 0; e_req = 0; e_done = 1; e_pass = 0; e_tmo = 1;
                        end
                    end
                    m_k++;
                end
                2: if (m_j == SET - 1) begin m_ph = 3; e_req = 1; end
                   else m_j++;
                default: if (ack) begin
                    m_ph = 0; e_req = 0; e_done = 1; e_pass = (rdata == m_exp); e_tmo = 0;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(req == e_req,   "R2 rd_req_o", req, e_req);
            chk(done == e_done, "R10 done_o",  done, e_done);
            chk(pass == e_pass, "R8 pass_o",   pass, e_pass);
            chk(tmo == e_tmo,   "R9 timeout_o", tmo, e_tmo);
        end
    end

    task automatic run(input logic [1:0] md, input logic [15:0] ex, input bit poke,
                       output int nreads);
        int r0;
        int w = 0;
        @(negedge clk);
        mode = md; expw = ex; start = 1'b1; r0 = reads;
        @(negedge clk);
        start = 1'b0;
        while (!done && w < 5000) begin
            @(negedge clk);
            w++;
            if (poke && w == 5) begin start = 1'b1; mode = 2'b01; end
            if (poke && w == 6) begin start = 1'b0; mode = md; end
        end
        if (w >= 5000) chk(1'b0, "watchdog R2", w, 0);
        nreads = reads - r0;
        @(negedge clk);
        chk(!done, "R10 done single cycle", done, 0);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req && !done && !pass && !tmo, "R1 reset state", {req, done, pass, tmo}, 0);

        // toggle mode, with a start pulse mid-poll that must be ignored
        resp_q = '{16'h0000, 16'h0040, 16'h0000, 16'h0040};
        run(2'b00, 16'h1234, 1'b1, n);
        chk(n == 9, "R3 toggle read count (R2 start ignored)", n, 9);
        chk(pass && !tmo, "R8 toggle pass", pass, 1);
        chk(last_low == SET, "R7 settle gap", last_low, SET);

        // toggle with a false completion that is rejected
        resp_q = '{16'h0000, 16'h0040, 16'h0040, 16'h0040, 16'h0000, 16'h0040, 16'h0000};
        run(2'b00, 16'h1234, 1'b0, n);
        chk(n == 11, "R5 rejected early completion", n, 11);
        chk(pass, "R5 pass after rejection", pass, 1);

        // program data polling with a spurious hit
        resp_q = '{16'h0025, 16'h0025, 16'h0025, 16'h0080, 16'h0000};
        run(2'b01, 16'h00A5, 1'b0, n);
        chk(n == 9, "R4 program data-poll read count", n, 9);
        chk(pass, "R4 program pass", pass, 1);

        // erase data polling
        resp_q = '{16'h0000, 16'h0000, 16'h0000, 16'h0000};
        run(2'b10, 16'hFFFF, 1'b0, n);
        chk(n == 8, "R4 erase data-poll read count", n, 8);
        chk(pass, "R4 erase pass", pass, 1);
        repeat (5) @(negedge clk);
        chk(pass && !tmo, "R8 flags held while idle", pass, 1);

        // erase where the final word does not match
        resp_q = '{16'h0000, 16'h0000, 16'hFF80, 16'hFF80, 16'hFF80, 16'hFF80};
        run(2'b10, 16'hFFFF, 1'b0, n);
        chk(n == 6, "R8 mismatch read count", n, 6);
        chk(!pass && !tmo, "R8 final mismatch fails", pass, 0);

        // security-ID: bit 7 already matches, only the toggle bit may end it
        resp_q = '{16'h0080, 16'h00C0, 16'h0080, 16'h00C0};
        run(2'b11, 16'h0080, 1'b0, n);
        chk(n == 9, "R6 security-ID ignores data bit", n, 9);
        chk(pass, "R6 security-ID pass", pass, 1);

        // never completes: timeout
        resp_q.delete();
        for (int i = 0; i < 100; i++) resp_q.push_back((i % 2) ? 16'h0040 : 16'h0000);
        run(2'b00, 16'h1234, 1'b0, n);
        chk(tmo == 1'b1, "R9 timeout flag", tmo, 1);
        chk(!pass, "R9 no pass on timeout", pass, 0);
        chk(n > 0 && n <= TMO, "R9 read count bounded", n, TMO);
        resp_q.delete();

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule